// File: doc/BRIEF.md
# Read Response Receiver

This block takes in the answers to read requests issued by the local node. A reply arrives on two valid/ready channels that run side by side. The header channel carries one decoded header word per reply. The payload channel carries 128-bit beats framed by start and end markers, with an empty-byte count on the final beat.

Before a read goes out, the local node records its transaction ID, priority and two node IDs in a small table inside the block. A reply completes only under three conditions:
- its header is well formed;
- it names a recorded read, with the two IDs exchanged and a higher priority;
- its payload length agrees with the header's byte count.

On completion the block gives a one-cycle done pulse. The pulse carries the assembled 256-bit result, the transaction ID and the four-bit status, and the table entry is released. A reply that fails its header check raises a header error. A reply whose payload framing or length is wrong raises a length error. Neither completes anything, and both leave the recorded read in place.

Top module: `rd_rsp_rx`

## Requirements
- R1: The header channel is ready only while no reply is in progress. The payload channel is ready only after a header has been taken and until its end-of-packet beat. A transfer happens only on a cycle where valid and ready are both high.
- R2: A read is recorded when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low while all table entries are in use, and a request offered then is ignored. A request whose transaction ID is already recorded leaves the table unchanged.
- R3: Header layout. The byte count is in bits [114:106] and bit 105 must be 0; bit 104 must be 0. Priority is in [103:102]. The ID mode is in [101:100] and must be 2'b01. The class is in [99:96] and must be 4'hD. Destination ID is in [95:80] and source ID in [79:64]. The kind is in [63:60] and must be 4'h8. Status is in [59:56] and transaction ID in [55:48]. Bits [47:0] must be zero. The transaction ID must match a recorded read.
- R4: The reply priority must be strictly greater than the priority recorded for the read.
- R5: The reply destination ID must equal the recorded source ID, and the reply source ID must equal the recorded destination ID.
- R6: A header failing R3 to R5 pulses `hdr_err_o` in the cycle after it is taken and completes nothing. The recorded read stays. If its byte count is nonzero, payload beats up to end-of-packet are consumed and discarded.
- R7: A payload fails when any of the following holds, and the reply then pulses `len_err_o` in the cycle after the end-of-packet beat, with no completion and the read kept:
  - the first beat lacks start-of-packet;
  - a later beat carries start-of-packet;
  - 16 × beats − empty differs from the byte count;
  - the byte count exceeds 32.
- R8: On success, `done_o` pulses in the cycle after the end-of-packet beat. Beat 0 appears in `done_data_o[127:0]` and beat 1 in `[255:128]`; a slot with no beat reads zero. The transaction ID and status are reported, and the read is released, so a repeat of the same reply raises `hdr_err_o`.
- R9: A valid header with byte count 0 completes in the cycle after it is taken, with no payload, zero data and its status.
- R10: After reset the header channel and the request port are ready, the payload channel is not, and `done_o`, `hdr_err_o` and `len_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Record an issued read |
| req_ready_o | output | 1 | Table has a free entry |
| req_tid_i | input | 8 | Transaction ID of the read |
| req_prio_i | input | 2 | Priority of the read |
| req_src_i | input | 16 | Local (source) node ID of the read |
| req_dst_i | input | 16 | Target node ID of the read |
| hd_valid_i | input | 1 | Header word valid |
| hd_ready_o | output | 1 | Header word accepted |
| hd_data_i | input | 115 | Reply header word |
| pd_valid_i | input | 1 | Payload beat valid |
| pd_ready_o | output | 1 | Payload beat accepted |
| pd_data_i | input | 128 | Payload beat |
| pd_sop_i | input | 1 | First payload beat |
| pd_eop_i | input | 1 | Last payload beat |
| pd_empty_i | input | 4 | Unused bytes on the last beat |
| done_o | output | 1 | Completion pulse |
| done_tid_o | output | 8 | Transaction ID of the completed read |
| done_status_o | output | 4 | Status of the completed read |
| done_data_o | output | 256 | Assembled result |
| hdr_err_o | output | 1 | Header rejected pulse |
| len_err_o | output | 1 | Payload framing or length error pulse |

## Verification
Each internal fault has a port-visible symptom and a timing signature:
- A stale or corrupted table entry shows up as a reply that should complete raising `hdr_err_o` instead, or the reverse. This appears one cycle after the header transfer.
- A missed release leaves the entry in place, so a repeated reply is wrongly accepted.
- A wrong beat counter shifts the result halves or flips the length verdict one cycle after end-of-packet.
- A wrong state register shows as both ready lines high, or as a ready line stuck low.

The sweeps cover every pair of request and reply priorities, every single-field header fault, and a grid of byte counts against beat counts and empty values. For each case the bench checks which pulse fires and in which cycle.

// File: rtl/rd_rsp_pkg.sv
package rd_rsp_pkg;
  localparam int unsigned TID_W  = 8;
  localparam int unsigned ID_W   = 16;
  localparam int unsigned PRIO_W = 2;
  localparam int unsigned SIZE_W = 9;
  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] FCLASS_RSP  = 4'hD;
  localparam logic [CODE_W-1:0] KIND_DATA   = 4'h8;
  localparam logic [1:0]        ID_MODE_16  = 2'b01;

  typedef struct packed {
    logic [SIZE_W-1:0] pld_bytes;
    logic              vchan;
    logic              flow_pri;
    logic [PRIO_W-1:0] prio;
    logic [1:0]        id_mode;
    logic [CODE_W-1:0] fclass;
    logic [ID_W-1:0]   dst_id;
    logic [ID_W-1:0]   src_id;
    logic [CODE_W-1:0] kind;
    logic [CODE_W-1:0] status;
    logic [TID_W-1:0]  tid;
    logic [47:0]       rsvd;
  } rsp_hdr_t;

  localparam int unsigned HDR_W = $bits(rsp_hdr_t);

  typedef struct packed {
    logic [TID_W-1:0]  tid;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   src;
    logic [ID_W-1:0]   dst;
  } rd_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DRAIN   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rsp_tag_table.sv
module rsp_tag_table
  import rd_rsp_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  rd_entry_t        alloc_ent_i,
  input  logic [TID_W-1:0] lkup_tid_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output rd_entry_t        hit_ent_o,
  input  logic             free_i,
  input  logic [IDX_W-1:0] free_idx_i,
  output logic             full_o
);
  logic [NSLOT-1:0] vld_q;
  rd_entry_t        ent_q [NSLOT];
  logic             dup;
  logic             have_free;
  logic [IDX_W-1:0] free_slot;

  // lowest index wins for both the lookup and the free-slot search
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    hit_ent_o = '0;
    dup       = 1'b0;
    have_free = 1'b0;
    free_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (vld_q[i] && ent_q[i].tid == lkup_tid_i) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
        hit_ent_o = ent_q[i];
      end
      if (vld_q[i] && ent_q[i].tid == alloc_ent_i.tid) dup = 1'b1;
      if (!vld_q[i]) begin
        have_free = 1'b1;
        free_slot = IDX_W'(i);
      end
    end
  end

  assign full_o = ~have_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < NSLOT; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (free_i && free_idx_i == IDX_W'(i)) vld_q[i] <= 1'b0;
        if (alloc_i && !dup && have_free && free_slot == IDX_W'(i)) begin
          vld_q[i] <= 1'b1;
          ent_q[i] <= alloc_ent_i;
        end
      end
    end
  end
endmodule

// File: rtl/rsp_hdr_check.sv
module rsp_hdr_check
  import rd_rsp_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 32
) (
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             hit_i,
  input  rd_entry_t        ent_i,
  output logic             ok_o,
  output logic             zero_len_o,
  output logic             oversize_o
);
  rsp_hdr_t h;
  logic     form_ok;
  logic     match_ok;

  assign h = rsp_hdr_t'(hdr_i);

  assign form_ok = (h.fclass == FCLASS_RSP) && (h.kind == KIND_DATA) &&
                   (h.id_mode == ID_MODE_16) && !h.vchan && !h.flow_pri &&
                   (h.rsvd == '0);

  // reply travels the other way, so its IDs are the request's swapped
  assign match_ok = hit_i && (h.prio > ent_i.prio) &&
                    (h.dst_id == ent_i.src) && (h.src_id == ent_i.dst);

  assign ok_o       = form_ok && match_ok;
  assign zero_len_o = (h.pld_bytes == '0);
  assign oversize_o = (h.pld_bytes > SIZE_W'(MAX_BYTES));
endmodule

// File: rtl/rsp_beat_collect.sv
module rsp_beat_collect #(
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned MAX_BEATS = 2,
  parameter int unsigned CNT_W     = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        beat_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [DATA_W*MAX_BEATS-1:0] data_o,
  output logic [CNT_W-1:0]            cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (beat_i && cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q <= '0;
      else if (clear_i)                         slot_q <= '0;
      else if (beat_i && cnt_q == CNT_W'(g))    slot_q <= data_i;
    end
    assign data_o[g*DATA_W +: DATA_W] = slot_q;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rd_rsp_rx.sv
module rd_rsp_rx
  import rd_rsp_pkg::*;
#(
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned MAX_BEATS = 2,
  parameter int unsigned NSLOT     = 4,
  localparam int unsigned EMPTY_W  = $clog2(DATA_W/8),
  localparam int unsigned RES_W    = DATA_W * MAX_BEATS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [TID_W-1:0]   req_tid_i,
  input  logic [PRIO_W-1:0]  req_prio_i,
  input  logic [ID_W-1:0]    req_src_i,
  input  logic [ID_W-1:0]    req_dst_i,
  input  logic               hd_valid_i,
  output logic               hd_ready_o,
  input  logic [HDR_W-1:0]   hd_data_i,
  input  logic               pd_valid_i,
  output logic               pd_ready_o,
  input  logic [DATA_W-1:0]  pd_data_i,
  input  logic               pd_sop_i,
  input  logic               pd_eop_i,
  input  logic [EMPTY_W-1:0] pd_empty_i,
  output logic               done_o,
  output logic [TID_W-1:0]   done_tid_o,
  output logic [CODE_W-1:0]  done_status_o,
  output logic [RES_W-1:0]   done_data_o,
  output logic               hdr_err_o,
  output logic               len_err_o
);
  localparam int unsigned IDX_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int unsigned CNT_W     = SIZE_W - EMPTY_W + 1;
  localparam int unsigned BYTES_W   = CNT_W + EMPTY_W;
  localparam int unsigned MAX_BYTES = RES_W / 8;

  rx_state_e         st_q;
  rsp_hdr_t          hdr;
  rd_entry_t         req_ent;
  rd_entry_t         hit_ent;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic              full;
  logic              hdr_ok, zero_len, oversize;
  logic              hd_fire, pd_fire, eop_fire;
  logic [CNT_W-1:0]  cnt;
  logic [BYTES_W-1:0] rx_bytes;
  logic              beat_bad, len_ok;
  logic              free_en;
  logic [IDX_W-1:0]  free_idx;
  logic              collect_clr, collect_beat;

  logic [IDX_W-1:0]  slot_q;
  logic [SIZE_W-1:0] size_q;
  logic              oversize_q;
  logic              sop_bad_q;
  logic [TID_W-1:0]  tid_q;
  logic [CODE_W-1:0] status_q;

  assign hdr     = rsp_hdr_t'(hd_data_i);
  assign req_ent = '{tid: req_tid_i, prio: req_prio_i, src: req_src_i, dst: req_dst_i};

  assign req_ready_o = ~full;
  assign hd_ready_o  = (st_q == ST_IDLE);
  assign pd_ready_o  = (st_q != ST_IDLE);
  assign hd_fire     = hd_valid_i && hd_ready_o;
  assign pd_fire     = pd_valid_i && pd_ready_o;
  assign eop_fire    = pd_fire && pd_eop_i;

  rsp_tag_table #(.NSLOT(NSLOT)) u_tab (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (req_valid_i && req_ready_o),
    .alloc_ent_i (req_ent),
    .lkup_tid_i  (hdr.tid),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .hit_ent_o   (hit_ent),
    .free_i      (free_en),
    .free_idx_i  (free_idx),
    .full_o      (full)
  );

  rsp_hdr_check #(.MAX_BYTES(MAX_BYTES)) u_chk_hdr (
    .hdr_i      (hd_data_i),
    .hit_i      (hit),
    .ent_i      (hit_ent),
    .ok_o       (hdr_ok),
    .zero_len_o (zero_len),
    .oversize_o (oversize)
  );

  assign collect_clr  = (st_q == ST_IDLE) && hd_fire;
  assign collect_beat = (st_q == ST_COLLECT) && pd_fire;

  rsp_beat_collect #(
    .DATA_W    (DATA_W),
    .MAX_BEATS (MAX_BEATS),
    .CNT_W     (CNT_W)
  ) u_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (collect_clr),
    .beat_i  (collect_beat),
    .data_i  (pd_data_i),
    .data_o  (done_data_o),
    .cnt_o   (cnt)
  );

  // bytes delivered so far including this beat, minus the tail padding
  assign rx_bytes = {cnt, {EMPTY_W{1'b0}}} + BYTES_W'(DATA_W/8) - BYTES_W'(pd_empty_i);
  assign beat_bad = pd_sop_i != (cnt == '0);
  assign len_ok   = !sop_bad_q && !beat_bad && !oversize_q &&
                    (rx_bytes == BYTES_W'(size_q));

  always_comb begin
    free_en  = 1'b0;
    free_idx = slot_q;
    if (st_q == ST_IDLE) begin
      free_idx = hit_idx;
      free_en  = hd_fire && hdr_ok && zero_len;
    end else if (st_q == ST_COLLECT) begin
      free_en  = eop_fire && len_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      slot_q        <= '0;
      size_q        <= '0;
      oversize_q    <= 1'b0;
      sop_bad_q     <= 1'b0;
      tid_q         <= '0;
      status_q      <= '0;
      done_o        <= 1'b0;
      done_tid_o    <= '0;
      done_status_o <= '0;
      hdr_err_o     <= 1'b0;
      len_err_o     <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      hdr_err_o <= 1'b0;
      len_err_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (hd_fire) begin
            slot_q     <= hit_idx;
            size_q     <= hdr.pld_bytes;
            oversize_q <= oversize;
            sop_bad_q  <= 1'b0;
            tid_q      <= hdr.tid;
            status_q   <= hdr.status;
            if (!hdr_ok) begin
              hdr_err_o <= 1'b1;
              st_q      <= zero_len ? ST_IDLE : ST_DRAIN;
            end else if (zero_len) begin
              done_o        <= 1'b1;
              done_tid_o    <= hdr.tid;
              done_status_o <= hdr.status;
            end else begin
              st_q <= ST_COLLECT;
            end
          end
        end
        ST_COLLECT: begin
          if (pd_fire && beat_bad) sop_bad_q <= 1'b1;
          if (eop_fire) begin
            st_q <= ST_IDLE;
            if (len_ok) begin
              done_o        <= 1'b1;
              done_tid_o    <= tid_q;
              done_status_o <= status_q;
            end else begin
              len_err_o <= 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (eop_fire) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_rsp_rx_chk.sv
module rd_rsp_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic hd_valid_i,
  input logic hd_ready_o,
  input logic pd_valid_i,
  input logic pd_ready_o,
  input logic pd_eop_i,
  input logic done_o,
  input logic hdr_err_o,
  input logic len_err_o
);
  // R1
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hd_ready_o && pd_ready_o));

  // R2
  slot_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> done_o);

  // R6
  hdr_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |-> $past(hd_valid_i && hd_ready_o));

  // R7
  len_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> $past(pd_valid_i && pd_ready_o && pd_eop_i));

  // R8
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(hd_valid_i && hd_ready_o) || $past(pd_valid_i && pd_ready_o && pd_eop_i)));

  // R8
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!hdr_err_o && !len_err_o));
endmodule

bind rd_rsp_rx rd_rsp_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .hd_valid_i  (hd_valid_i),
  .hd_ready_o  (hd_ready_o),
  .pd_valid_i  (pd_valid_i),
  .pd_ready_o  (pd_ready_o),
  .pd_eop_i    (pd_eop_i),
  .done_o      (done_o),
  .hdr_err_o   (hdr_err_o),
  .len_err_o   (len_err_o)
);

// File: tb/sim_rd_rsp_rx.sv
`timescale 1ns/1ps
module sim_rd_rsp_rx;
  import rd_rsp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_tid = '0;
  logic [1:0] req_prio = '0;
  logic [15:0] req_src = '0, req_dst = '0;
  logic hd_valid = 1'b0, hd_ready;
  logic [HDR_W-1:0] hd_data = '0;
  logic pd_valid = 1'b0, pd_ready;
  logic [127:0] pd_data = '0;
  logic pd_sop = 1'b0, pd_eop = 1'b0;
  logic [3:0] pd_empty = '0;
  logic done;
  logic [7:0] done_tid;
  logic [3:0] done_status;
  logic [255:0] done_data;
  logic hdr_err, len_err;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  int n_done = 0, n_herr = 0, n_lerr = 0;
  int d_cyc = 0, h_cyc = 0, l_cyc = 0;
  logic [7:0] d_tid;
  logic [3:0] d_st;
  logic [255:0] d_data;

  rd_rsp_rx u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_tid_i(req_tid),
    .req_prio_i(req_prio), .req_src_i(req_src), .req_dst_i(req_dst),
    .hd_valid_i(hd_valid), .hd_ready_o(hd_ready), .hd_data_i(hd_data),
    .pd_valid_i(pd_valid), .pd_ready_o(pd_ready), .pd_data_i(pd_data),
    .pd_sop_i(pd_sop), .pd_eop_i(pd_eop), .pd_empty_i(pd_empty),
    .done_o(done), .done_tid_o(done_tid), .done_status_o(done_status),
    .done_data_o(done_data), .hdr_err_o(hdr_err), .len_err_o(len_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin n_done++; d_cyc = cyc; d_tid = done_tid; d_st = done_status; d_data = done_data; end
      if (hdr_err) begin n_herr++; h_cyc = cyc; end
      if (len_err) begin n_lerr++; l_cyc = cyc; end
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string r, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", r, what);
    end
  endtask

  function automatic logic [HDR_W-1:0] mk_hdr(int sz, int pr, logic [3:0] fc, logic [15:0] d,
                                               logic [15:0] s, logic [3:0] kd, logic [3:0] st,
                                               logic [7:0] tid);
    rsp_hdr_t h;
    h = '0;
    h.pld_bytes = 9'(sz);
    h.prio = 2'(pr);
    h.id_mode = 2'b01;
    h.fclass = fc;
    h.dst_id = d;
    h.src_id = s;
    h.kind = kd;
    h.status = st;
    h.tid = tid;
    return h;
  endfunction

  function automatic logic [127:0] beat(logic [7:0] tid, int b);
    return {4{tid, 8'(b), 16'hA5C3}};
  endfunction

  function automatic logic [255:0] exp_data(logic [7:0] tid, int nb);
    logic [255:0] v;
    v = '0;
    if (nb >= 1) v[127:0] = beat(tid, 0);
    if (nb >= 2) v[255:128] = beat(tid, 1);
    return v;
  endfunction

  task automatic add_req(logic [7:0] tid, int pr, logic [15:0] s, logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_tid = tid; req_prio = 2'(pr); req_src = s; req_dst = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rsp(input logic [HDR_W-1:0] h, input int nb, input int e, input bit sop_ok,
                     output int hc, output int ec);
    rsp_hdr_t hh;
    hh = rsp_hdr_t'(h);
    n_done = 0; n_herr = 0; n_lerr = 0;
    @(negedge clk);
    hd_valid = 1'b1; hd_data = h;
    while (!hd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hc = cyc; ec = cyc;
    hd_valid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      pd_valid = 1'b1;
      pd_data = beat(hh.tid, b);
      pd_sop = (b == 0) && sop_ok;
      pd_eop = (b == nb - 1);
      pd_empty = (b == nb - 1) ? 4'(e) : 4'd0;
      while (!pd_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      ec = cyc;
    end
    pd_valid = 1'b0; pd_sop = 1'b0; pd_eop = 1'b0; pd_empty = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_res(string r, string what, bit ed, bit eh, bit el, int hc, int ec,
                            logic [7:0] tid, logic [3:0] st, logic [255:0] dat);
    chk(n_done == int'(ed), r, $sformatf("%s done count act=%0d exp=%0d", what, n_done, ed));
    chk(n_herr == int'(eh), r, $sformatf("%s hdr_err count act=%0d exp=%0d", what, n_herr, eh));
    chk(n_lerr == int'(el), r, $sformatf("%s len_err count act=%0d exp=%0d", what, n_lerr, el));
    if (ed && n_done == 1) begin
      chk(d_cyc == ec, r, $sformatf("%s done cycle act=%0d exp=%0d", what, d_cyc, ec));
      chk(d_tid == tid, r, $sformatf("%s tid act=%h exp=%h", what, d_tid, tid));
      chk(d_st == st, r, $sformatf("%s status act=%h exp=%h", what, d_st, st));
      chk(d_data == dat, r, $sformatf("%s data act=%h exp=%h", what, d_data, dat));
    end
    if (eh && n_herr == 1) chk(h_cyc == hc, r, $sformatf("%s hdr_err cycle act=%0d exp=%0d", what, h_cyc, hc));
    if (el && n_lerr == 1) chk(l_cyc == ec, r, $sformatf("%s len_err cycle act=%0d exp=%0d", what, l_cyc, ec));
  endtask

  // complete an outstanding read with a correct prio-3, 32-byte reply
  task automatic good_rsp(string r, logic [7:0] tid, logic [15:0] s, logic [15:0] d);
    int hc, ec;
    rsp(mk_hdr(32, 3, 4'hD, s, d, 4'h8, 4'h0, tid), 2, 0, 1'b1, hc, ec);
    expect_res(r, $sformatf("cleanup tid=%h", tid), 1, 0, 0, hc, ec, tid, 4'h0, exp_data(tid, 2));
  endtask

  initial begin
    int hc, ec;
    int sizes[6] = '{1, 16, 17, 32, 33, 48};
    logic [7:0] t;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(hd_ready === 1'b1, "R10", $sformatf("hd_ready act=%b exp=1", hd_ready));
    chk(pd_ready === 1'b0, "R10", $sformatf("pd_ready act=%b exp=0", pd_ready));
    chk(req_ready === 1'b1, "R10", $sformatf("req_ready act=%b exp=1", req_ready));
    chk({done, hdr_err, len_err} === 3'b000, "R10",
        $sformatf("pulses act=%b exp=000", {done, hdr_err, len_err}));

    // R4 priority sweep; R6 entry survives a rejected header
    for (int rp = 0; rp < 3; rp++) begin
      for (int sp = 0; sp < 4; sp++) begin
        t = 8'(8'h10 + rp * 4 + sp);
        add_req(t, rp, 16'h0100 + 16'(t), 16'h0200 + 16'(t));
        rsp(mk_hdr(32, sp, 4'hD, 16'h0100 + 16'(t), 16'h0200 + 16'(t), 4'h8, 4'h0, t), 2, 0, 1'b1, hc, ec);
        expect_res("R4", $sformatf("req prio %0d rsp prio %0d", rp, sp), sp > rp, sp <= rp, 0,
                   hc, ec, t, 4'h0, exp_data(t, 2));
        chk(!pd_ready && hd_ready, "R1", $sformatf("channels after reply act=%b%b exp=10", hd_ready, pd_ready));
        if (sp <= rp) good_rsp("R6", t, 16'h0100 + 16'(t), 16'h0200 + 16'(t));
      end
    end

    // R3 / R5 single-field header faults, payload drained (R6)
    add_req(8'h40, 0, 16'h1111, 16'h2222);
    for (int k = 0; k < 8; k++) begin
      logic [HDR_W-1:0] h;
      rsp_hdr_t hs;
      h = mk_hdr(32, 1, 4'hD, 16'h1111, 16'h2222, 4'h8, 4'h0, 8'h40);
      hs = rsp_hdr_t'(h);
      case (k)
        0: hs.fclass = 4'h2;
        1: hs.kind = 4'h4;
        2: hs.tid = 8'h41;
        3: hs.dst_id = 16'h2222;
        4: hs.src_id = 16'h1111;
        5: hs.id_mode = 2'b00;
        6: hs.rsvd = 48'h1;
        default: hs.vchan = 1'b1;
      endcase
      rsp(hs, 2, 0, 1'b1, hc, ec);
      expect_res((k == 3 || k == 4) ? "R5" : "R3", $sformatf("header fault %0d", k), 0, 1, 0,
                 hc, ec, 8'h40, 4'h0, '0);
    end
    good_rsp("R6", 8'h40, 16'h1111, 16'h2222);
    // R8 entry released: the same reply again is rejected
    rsp(mk_hdr(32, 3, 4'hD, 16'h1111, 16'h2222, 4'h8, 4'h0, 8'h40), 2, 0, 1'b1, hc, ec);
    expect_res("R8", "repeat after release", 0, 1, 0, hc, ec, 8'h40, 4'h0, '0);

    // R9 zero-length reply with non-done status
    add_req(8'h50, 1, 16'h0A0A, 16'h0B0B);
    rsp(mk_hdr(0, 2, 4'hD, 16'h0A0A, 16'h0B0B, 4'h8, 4'h7, 8'h50), 0, 0, 1'b1, hc, ec);
    expect_res("R9", "zero length", 1, 0, 0, hc, ec, 8'h50, 4'h7, '0);

    // R7 / R8 byte count against beat count and empty
    for (int si = 0; si < 6; si++) begin
      for (int nb = 1; nb <= 3; nb++) begin
        int sz, e;
        bit good;
        sz = sizes[si];
        e = (nb * 16 >= sz && nb * 16 - sz < 16) ? nb * 16 - sz : 0;
        good = (nb * 16 - e == sz) && (sz <= 32);
        t = 8'(8'h60 + si * 4 + nb);
        add_req(t, 0, 16'h0C00 + 16'(t), 16'h0D00);
        rsp(mk_hdr(sz, 1, 4'hD, 16'h0C00 + 16'(t), 16'h0D00, 4'h8, 4'h3, t), nb, e, 1'b1, hc, ec);
        expect_res(good ? "R8" : "R7", $sformatf("size %0d beats %0d empty %0d", sz, nb, e),
                   good, 0, !good, hc, ec, t, 4'h3, exp_data(t, nb));
        if (!good) good_rsp("R7", t, 16'h0C00 + 16'(t), 16'h0D00);
      end
    end
    // R7 missing start-of-packet
    add_req(8'h7F, 0, 16'h0E0E, 16'h0F0F);
    rsp(mk_hdr(32, 1, 4'hD, 16'h0E0E, 16'h0F0F, 4'h8, 4'h0, 8'h7F), 2, 0, 1'b0, hc, ec);
    expect_res("R7", "no sop", 0, 0, 1, hc, ec, 8'h7F, 4'h0, '0);
    good_rsp("R7", 8'h7F, 16'h0E0E, 16'h0F0F);

    // R2 table full, ignored request, duplicate tag
    for (int i = 0; i < 4; i++) add_req(8'(8'h80 + i), 0, 16'h3000, 16'h4000);
    chk(req_ready === 1'b0, "R2", $sformatf("req_ready when full act=%b exp=0", req_ready));
    add_req(8'h84, 0, 16'h3000, 16'h4000);
    rsp(mk_hdr(32, 3, 4'hD, 16'h3000, 16'h4000, 4'h8, 4'h0, 8'h84), 2, 0, 1'b1, hc, ec);
    expect_res("R2", "request while full", 0, 1, 0, hc, ec, 8'h84, 4'h0, '0);
    for (int i = 0; i < 4; i++) good_rsp("R2", 8'(8'h80 + i), 16'h3000, 16'h4000);
    chk(req_ready === 1'b1, "R2", $sformatf("req_ready after release act=%b exp=1", req_ready));
    add_req(8'h90, 0, 16'h5000, 16'h6000);
    add_req(8'h90, 2, 16'h5000, 16'h6000);
    rsp(mk_hdr(32, 1, 4'hD, 16'h5000, 16'h6000, 4'h8, 4'h0, 8'h90), 2, 0, 1'b1, hc, ec);
    expect_res("R2", "duplicate tag keeps first", 1, 0, 0, hc, ec, 8'h90, 4'h0, exp_data(8'h90, 2));

    report();
    $finish;
  end
endmodule